// File: doc/BRIEF.md
# Single-Register I2C Control Target

This block is an I2C target that owns one 8-bit control and status byte for a supply-and-signalling controller. Six upper bits are control settings written by the bus master; the two lowest bit positions are never stored and instead report two live diagnostic flags supplied by neighbouring logic. There is no sub-address. The first data byte after a write address goes straight into the register, and a read returns the byte at once.

The bus lines enter through two-flop synchronisers and are sampled on the system clock. The data line is driven as an active-low open-drain enable (`sda_oe` high pulls the line low). Two strap inputs select the two low bits of the 7-bit address, so four targets can share one bus. A supply-good input overrides everything: while it is low the register is held at zero and the target never acknowledges.

Top module: `ctl_reg_i2c_target`

## Requirements
- R1: After reset `ctrl_bits` is 0 and `sda_oe` is 0.
- R2: The target acknowledges an address byte (pulls SDA low on the ninth clock) only when its upper seven bits equal 0b00010 followed by `addr_sel[1:0]`. Bit 0 of that byte selects the direction: 0 means write and 1 means read. Every other address gets no acknowledge.
- R3: After an address mismatch the target ignores all following bytes until the next START. It gives no acknowledge and does not change the register.
- R4: Each write data byte is acknowledged. Its bits 7..2 are stored into `ctrl_bits[5:0]`, with byte bit 7 going to `ctrl_bits[5]`. Its bits 1..0 have no effect.
- R5: In a write with several data bytes, each byte overwrites the register in turn.
- R6: A read returns `{ctrl_bits[5:0], diag_flags[1:0]}` MSB first, with `diag_flags[1]` at bit 1 and `diag_flags[0]` at bit 0.
- R7: When the master acknowledges a read byte, the target sends the byte again, with the flags sampled afresh at the start of that byte. When the master does not acknowledge, the target releases SDA and stops driving.
- R8: While `supply_ok` is low, `ctrl_bits` is 0 and no byte is acknowledged. The register stays 0 after supply returns, until the next write.
- R9: A STOP or START received in the middle of a byte abandons the transfer. The partial byte is not written.
- R10: `sda_oe` changes only while the synchronised SCL is low, so SDA never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | High when the supply is above the lockout threshold |
| addr_sel | input | 2 | Strap value for the two low address bits |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| diag_flags | input | 2 | Live diagnostic flags: [1] over-temperature, [0] overload |
| ctrl_bits | output | 6 | Stored control bits |

## Verification
The bench sweeps all four strap values against all four valid addresses and one foreign address. Matching only the upper five bits would wrongly acknowledge a neighbour's traffic; a design that forgot to fall silent after a mismatch would store a byte meant for another target.

All 64 control values are written with changing low bits and read back. A design that stored the low bits, or returned stale flags, would show up in that readback. Changing the flags between two acknowledged read bytes exposes a design that latches the byte only once.

Aborted bytes, writes under lockout and the hold time of SDA during SCL high target designs that commit partial data, acknowledge without supply, or move SDA on the wrong clock phase.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int CTRL_W = 6;
    localparam int FLAG_W = BYTE_W - CTRL_W;
    localparam int ADDR_W = 7;
    localparam int SEL_W  = 2;
    localparam int BASE_W = ADDR_W - SEL_W;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_ADDR_CHK, S_ADDR_ACK,
        S_WDATA, S_WCHK, S_WACK,
        S_RDATA, S_RACK, S_RNEXT
    } tgt_st_e;

    typedef struct packed {
        tgt_st_e             st;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   rx;
        logic [BYTE_W-1:0]   tx;
        logic                rw;
        logic                oe;
        logic [CTRL_W-1:0]   ctrl;
    } tgt_reg_t;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain_q[s] <= RST_VAL;
            else if (s == 0) chain_q[s] <= d;
            else             chain_q[s] <= chain_q[(s == 0) ? 0 : s - 1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bus_event_det.sv
module bus_event_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic ev_start,
    output logic ev_stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    assign ev_start = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign ev_stop  = scl_s & scl_p_q & ~sda_p_q & sda_s;
    assign scl_rise = scl_s & ~scl_p_q;
    assign scl_fall = ~scl_s & scl_p_q;
endmodule

// File: rtl/ctl_reg_i2c_target.sv
module ctl_reg_i2c_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [BASE_W-1:0] ADDR_BASE   = 5'b00010,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic [SEL_W-1:0]  addr_sel,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [FLAG_W-1:0] diag_flags,
    output logic [CTRL_W-1:0] ctrl_bits
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [1:0] line_s;
    logic scl_s, sda_s;
    logic ev_start, ev_stop, scl_rise, scl_fall;
    tgt_reg_t cur_q, nx_d;
    logic [BYTE_W-1:0] rd_byte;
    tgt_st_e st_now;
    logic [BYTE_W-1:0] rx_now;

    bit_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    bus_event_det u_evt (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .ev_start(ev_start), .ev_stop(ev_stop),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    assign rd_byte = {cur_q.ctrl, diag_flags};

    always_comb begin
        nx_d = cur_q;
        if (!supply_ok) begin
            nx_d = '0;
        end else if (ev_start) begin
            nx_d.st  = S_ADDR;
            nx_d.cnt = '0;
            nx_d.oe  = 1'b0;
        end else if (ev_stop) begin
            nx_d.st = S_IDLE;
            nx_d.oe = 1'b0;
        end else begin
            unique case (cur_q.st)
                S_ADDR, S_WDATA: if (scl_rise) begin
                    nx_d.rx  = {cur_q.rx[BYTE_W-2:0], sda_s};
                    nx_d.cnt = cur_q.cnt + 1'b1;
                    if (cur_q.cnt == LAST)
                        nx_d.st = (cur_q.st == S_ADDR) ? S_ADDR_CHK : S_WCHK;
                end
                S_ADDR_CHK: if (scl_fall) begin
                    if (cur_q.rx[BYTE_W-1:1] == {ADDR_BASE, addr_sel}) begin
                        nx_d.st = S_ADDR_ACK;
                        nx_d.oe = 1'b1;
                        nx_d.rw = cur_q.rx[0];
                    end else begin
                        nx_d.st = S_IDLE;
                    end
                end
                S_ADDR_ACK, S_RNEXT: if (scl_fall) begin
                    nx_d.cnt = '0;
                    if (cur_q.st == S_RNEXT || cur_q.rw) begin
                        nx_d.tx = rd_byte;
                        nx_d.oe = ~rd_byte[BYTE_W-1];
                        nx_d.st = S_RDATA;
                    end else begin
                        nx_d.oe = 1'b0;
                        nx_d.st = S_WDATA;
                    end
                end
                S_WCHK: if (scl_fall) begin
                    nx_d.ctrl = cur_q.rx[BYTE_W-1 -: CTRL_W];
                    nx_d.oe   = 1'b1;
                    nx_d.st   = S_WACK;
                end
                S_WACK: if (scl_fall) begin
                    nx_d.oe  = 1'b0;
                    nx_d.cnt = '0;
                    nx_d.st  = S_WDATA;
                end
                S_RDATA: if (scl_fall) begin
                    if (cur_q.cnt == LAST) begin
                        nx_d.oe = 1'b0;
                        nx_d.st = S_RACK;
                    end else begin
                        nx_d.tx  = {cur_q.tx[BYTE_W-2:0], 1'b0};
                        nx_d.oe  = ~cur_q.tx[BYTE_W-2];
                        nx_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                S_RACK: if (scl_rise) begin
                    nx_d.st = sda_s ? S_IDLE : S_RNEXT;
                end
                default: nx_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nx_d;
    end

    assign sda_oe    = cur_q.oe;
    assign ctrl_bits = cur_q.ctrl;
    assign st_now    = cur_q.st;
    assign rx_now    = cur_q.rx;
endmodule

// File: rtl/ctl_reg_i2c_checker.sv
module ctl_reg_i2c_checker
    import i2c_tgt_pkg::*;
#(
    parameter logic [BASE_W-1:0] ADDR_BASE = 5'b00010
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic [SEL_W-1:0]  addr_sel,
    input logic              sda_oe,
    input logic              scl_s,
    input logic              ev_stop,
    input tgt_st_e           st_now,
    input logic [BYTE_W-1:0] rx_now,
    input logic [CTRL_W-1:0] ctrl_bits
);
    // R8: lockout clears the register and silences the target
    a_r8_lockout_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (ctrl_bits == '0 && !sda_oe));

    // R4: the register moves only on a completed write byte or lockout
    a_r4_ctrl_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_bits) |-> ($past(st_now) == S_WCHK || !$past(supply_ok)));

    // R2: an address acknowledge starts only on a matching byte
    a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && st_now == S_ADDR_ACK)
            |-> (rx_now[BYTE_W-1:1] == {ADDR_BASE, addr_sel}));

    // R9: a STOP returns the target to idle with SDA released
    a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && supply_ok) |=> (st_now == S_IDLE && !sda_oe));

    // R10: the data line drive changes only while SCL is low
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && $past(supply_ok) && !$stable(sda_oe)) |-> !scl_s);
endmodule

bind ctl_reg_i2c_target ctl_reg_i2c_checker #(.ADDR_BASE(ADDR_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .scl_s(scl_s), .ev_stop(ev_stop), .st_now(st_now),
    .rx_now(rx_now), .ctrl_bits(ctrl_bits)
);

// File: tb/ctl_reg_i2c_target_test.sv
`timescale 1ns/1ps
module ctl_reg_i2c_target_test;
    localparam int HP = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic [1:0] addr_sel = 2'd0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [1:0] diag = 2'b00;
    logic sda_oe;
    logic [5:0] ctrl_bits;
    logic sda_line;
    int checks = 0;
    int errors = 0;
    bit hold_bad = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    ctl_reg_i2c_target uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .addr_sel(addr_sel),
        .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .diag_flags(diag), .ctrl_bits(ctrl_bits)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic phase();
        repeat (HP) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; phase();
        m_scl = 1'b1; phase();
        m_sda = 1'b0; phase();
        m_scl = 1'b0; phase();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; phase();
        m_scl = 1'b1; phase();
        m_sda = 1'b1; phase();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    phase();
        m_scl = 1'b1; phase();
        m_scl = 1'b0; phase();
    endtask

    task automatic get_bit(output logic b);
        logic first;
        m_sda = 1'b1; phase();
        m_scl = 1'b1;
        repeat (2) @(negedge clk);
        first = sda_line;
        repeat (HP/2 - 2) @(negedge clk);
        b = sda_line;
        repeat (HP - HP/2 - 1) @(negedge clk);
        if (sda_line != first) hold_bad = 1'b1;
        @(negedge clk);
        m_scl = 1'b0; phase();
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(a);
        ack = ~a;
    endtask

    task automatic read_byte(output logic [7:0] v, input logic mack);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        send_bit(~mack);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d,
                            output logic acka, output logic ackd);
        bus_start();
        write_byte({a, 1'b0}, acka);
        write_byte(d, ackd);
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] a, output logic acka, output logic [7:0] v);
        bus_start();
        write_byte({a, 1'b1}, acka);
        read_byte(v, 1'b0);
        bus_stop();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual %0h expected %0h", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic acka, ackd;
        logic [7:0] rb, rb2;
        logic [5:0] exp_ctrl;
        logic [6:0] a;
        logic [7:0] d;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(ctrl_bits == 6'd0, "R1 ctrl after reset", ctrl_bits, 0);
        check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        exp_ctrl = 6'd0;

        // R2/R3: every strap against every valid address and one foreign one
        for (int s = 0; s < 4; s++) begin
            addr_sel = 2'(s);
            for (int t = 0; t < 5; t++) begin
                a = (t < 4) ? {5'b00010, 2'(t)} : 7'h50;
                d = {2'(s), 3'(t), 3'b101};
                do_write(a, d, acka, ackd);
                if (t == s) begin
                    exp_ctrl = d[7:2];
                    check(acka, "R2 address ack on match", acka, 1);
                    check(ackd, "R4 data ack", ackd, 1);
                end else begin
                    check(!acka, "R2 no ack on mismatch", acka, 0);
                    check(!ackd, "R3 data ignored after mismatch", ackd, 0);
                end
                check(ctrl_bits == exp_ctrl, "R3/R4 register value", ctrl_bits, exp_ctrl);
            end
        end

        // R4/R6: every control value, low write bits varied, live flags
        addr_sel = 2'd2;
        for (int v = 0; v < 64; v++) begin
            diag = 2'(v);
            do_write(7'b0001010, {6'(v), 2'(v) ^ 2'b10}, acka, ackd);
            check(ctrl_bits == 6'(v), "R4 stored bits", ctrl_bits, v);
            do_read(7'b0001010, acka, rb);
            check(acka && rb == {6'(v), 2'(v)}, "R6 read byte", rb, {6'(v), 2'(v)});
        end

        // R5: multi-byte write, each byte overwrites
        bus_start();
        write_byte(8'h14, acka);
        write_byte(8'hA4, ackd);
        check(ctrl_bits == 6'h29, "R5 first byte", ctrl_bits, 6'h29);
        write_byte(8'h58, ackd);
        check(ctrl_bits == 6'h16, "R5 second byte", ctrl_bits, 6'h16);
        write_byte(8'hFC, ackd);
        check(ackd && ctrl_bits == 6'h3F, "R5 third byte", ctrl_bits, 6'h3F);
        bus_stop();

        // R7: master ack repeats the byte with fresh flags, nack releases
        do_write(7'b0001010, 8'h94, acka, ackd);
        diag = 2'b01;
        bus_start();
        write_byte(8'h15, acka);
        for (int i = 7; i >= 0; i--) get_bit(rb[i]);
        diag = 2'b10;
        send_bit(1'b0);
        read_byte(rb2, 1'b0);
        check(rb == 8'h95, "R7 first read byte", rb, 8'h95);
        check(rb2 == 8'h96, "R7 repeated byte with fresh flags", rb2, 8'h96);
        check(sda_oe == 1'b0, "R7 release after nack", sda_oe, 0);
        bus_stop();

        // R9: STOP and repeated START in the middle of a byte
        bus_start();
        write_byte(8'h14, acka);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        check(ctrl_bits == 6'h25, "R9 stop mid byte", ctrl_bits, 6'h25);
        bus_start();
        write_byte(8'h14, acka);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_start();
        write_byte(8'h15, acka);
        read_byte(rb, 1'b0);
        bus_stop();
        check(acka && rb == 8'h96, "R9 restart mid byte", rb, 8'h96);

        // R8: lockout
        supply_ok = 1'b0;
        repeat (4) @(negedge clk);
        check(ctrl_bits == 6'd0, "R8 cleared in lockout", ctrl_bits, 0);
        do_write(7'b0001010, 8'hFC, acka, ackd);
        check(!acka && !ackd, "R8 no ack in lockout", {acka, ackd}, 0);
        supply_ok = 1'b1;
        repeat (4) @(negedge clk);
        check(ctrl_bits == 6'd0, "R8 zero after supply returns", ctrl_bits, 0);
        do_read(7'b0001010, acka, rb);
        check(acka && rb == 8'h02, "R8 readback after lockout", rb, 8'h02);

        check(!hold_bad, "R10 SDA stable while SCL high", hold_bad, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule